// File: doc/BRIEF.md
# ADC Serial Command Sequencer

This block is a serial-bus master that talks to an external delta-sigma converter. It runs on the converter's own master clock and divides that clock down to form the serial clock. One request on a valid/ready port starts a whole transaction: the block lowers chip select, shifts out the command bytes, waits a fixed number of master-clock periods when the converter needs time before it answers, clocks in the response and then releases chip select.

Three request kinds are supported: reading one configuration register, writing one configuration register, and fetching one 24-bit conversion result. While it clocks in a response, the block drives only zero bytes on its data output. The converter treats a zero byte as a no-operation, so no stray command is sent during readout. Read results come back on a 24-bit bus with a one-cycle valid pulse. Timing is set by two parameters counted in master-clock cycles: `DIV_CYC`, the serial clock period (default 4), and `WAIT_CYC`, the response wait (default 50).

Top module: `adc_cmd_seq`

## Requirements
- R1: `reqReady` is high only while the block is idle with `spiCsN` high. A request that arrives during a transaction is not accepted until chip select has been released.
- R2: `spiSclk` idles low and toggles only while `spiCsN` is low. Each high phase and each low phase lasts at least `DIV_CYC/2` master clocks, so the serial clock never runs faster than one quarter of the master clock at the default setting.
- R3: Bytes are sent MSB first. `spiMosi` changes only on rising `spiSclk` edges and holds steady through each high phase. `spiMiso` is sampled on falling edges.
- R4: A register read (`reqKind` = 0) sends `{4'h1, reqAddr}` and then 0x00, waits, and clocks in one byte while sending 0x00. That byte is returned in `rspData[7:0]`, with `rspData[23:8]` set to zero.
- R5: A register write (`reqKind` = 1) sends `{4'h5, reqAddr}`, then 0x00, then `reqData`, with no wait phase and no `rspValid` pulse. A value written this way reads back unchanged, for example 0x33 at address 3.
- R6: A data read (`reqKind` = 2) sends 0x03, waits, and then clocks in three bytes while sending 0x00. The bytes are assembled MSB first into `rspData[23:0]`.
- R7: For register reads and data reads, at least `WAIT_CYC` master-clock periods pass between the last falling `spiSclk` edge of the command bytes and the first rising edge of the response.
- R8: `spiCsN` stays low from acceptance until the last byte is done. For a read, `rspValid` is a single-cycle pulse that rises on the same edge as `spiCsN`.
- R9: After reset, `spiCsN` = 1, `spiSclk` = 0, `spiMosi` = 0, `rspValid` = 0 and `reqReady` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock, the timing base of the block |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The block can accept a request this cycle |
| reqKind | input | 2 | 0 = register read, 1 = register write, 2 = data read |
| reqAddr | input | 4 | Register address |
| reqData | input | 8 | Register write value |
| rspValid | output | 1 | One-cycle pulse: read result is valid |
| rspData | output | 24 | Read result (register reads use bits 7:0) |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the converter |
| spiMiso | input | 1 | Serial data from the converter |

## Verification
The properties assume that a request is only offered with `reqKind` in the range 0 to 2. They also assume that `reqKind` holds steady on the cycle the request is accepted, since the checker latches it at that cycle to decide which bits belong to the command and which to the response. The bench drives requests only from the idle state with legal kinds, and it drops `reqValid` right after acceptance. Its converter model changes `spiMiso` only on rising serial-clock edges, so the data is stable when it is sampled on the falling edge.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;

  typedef enum logic [1:0] {
    KIND_RREG  = 2'd0,
    KIND_WREG  = 2'd1,
    KIND_RDATA = 2'd2,
    KIND_SPARE = 2'd3
  } kind_e;

  localparam logic [3:0] OP_RREG_HI = 4'h1;
  localparam logic [3:0] OP_WREG_HI = 4'h5;
  localparam logic [7:0] OP_RDATA   = 8'h03;
  localparam logic [7:0] OP_NOP     = 8'h00;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;
    logic       rise;
    logic       fall;
    logic       clrMosi;
    logic [2:0] bitIdx;
    logic [1:0] byteIdx;
  } stb_t;

  function automatic logic [2:0] cmdBytes(kind_e k);
    case (k)
      KIND_WREG:  return 3'd3;
      KIND_RDATA: return 3'd1;
      default:    return 3'd2;
    endcase
  endfunction

  function automatic logic [2:0] rspBytes(kind_e k);
    case (k)
      KIND_WREG:  return 3'd0;
      KIND_RDATA: return 3'd3;
      default:    return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/adcseq_ctrl.sv
`timescale 1ns/1ps
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DIV_CYC  = 4,
  parameter int WAIT_CYC = 50
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  reqValid,
  input  kind_e reqKind,
  output logic  reqReady,
  output logic  spiCsN,
  output logic  spiSclk,
  output logic  rspValid,
  output stb_t  stb
);

  localparam int HALF    = DIV_CYC / 2;
  localparam int CNT_MAX = (WAIT_CYC > HALF) ? WAIT_CYC : HALF;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_WAIT, ST_FIN
  } st_e;

  st_e          state, nxtState;
  logic [CW-1:0] cnt, nxtCnt;
  logic [2:0]   bitIdx;
  logic [1:0]   byteIdx;
  kind_e        kindQ;
  logic         lastCmd, lastAll;

  assign lastCmd  = ({1'b0, byteIdx} == cmdBytes(kindQ) - 3'd1);
  assign lastAll  = ({1'b0, byteIdx} == cmdBytes(kindQ) + rspBytes(kindQ) - 3'd1);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nxtState    = state;
    nxtCnt      = (cnt != '0) ? cnt - 1'b1 : cnt;
    stb         = '0;
    stb.bitIdx  = bitIdx;
    stb.byteIdx = byteIdx;
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.accept = 1'b1;
        nxtState   = ST_SETUP;
        nxtCnt     = CW'(HALF - 1);
      end
      ST_SETUP: if (cnt == '0) begin
        nxtState    = ST_HIGH;
        nxtCnt      = CW'(HALF - 1);
        stb.rise    = 1'b1;
        stb.bitIdx  = 3'd0;
        stb.byteIdx = 2'd0;
      end
      ST_HIGH: if (cnt == '0) begin
        nxtState = ST_LOW;
        nxtCnt   = CW'(HALF - 1);
        stb.fall = 1'b1;
      end
      ST_LOW: if (cnt == '0) begin
        if (bitIdx != 3'd7) begin
          nxtState   = ST_HIGH;
          nxtCnt     = CW'(HALF - 1);
          stb.rise   = 1'b1;
          stb.bitIdx = bitIdx + 3'd1;
        end else if (lastAll) begin
          nxtState    = ST_FIN;
          stb.clrMosi = 1'b1;
        end else if (lastCmd) begin
          nxtState    = ST_WAIT;
          nxtCnt      = CW'(WAIT_CYC - 1);
          stb.clrMosi = 1'b1;
          stb.bitIdx  = 3'd0;
          stb.byteIdx = byteIdx + 2'd1;
        end else begin
          nxtState    = ST_HIGH;
          nxtCnt      = CW'(HALF - 1);
          stb.rise    = 1'b1;
          stb.bitIdx  = 3'd0;
          stb.byteIdx = byteIdx + 2'd1;
        end
      end
      ST_WAIT: if (cnt == '0) begin
        nxtState = ST_HIGH;
        nxtCnt   = CW'(HALF - 1);
        stb.rise = 1'b1;
      end
      ST_FIN:  nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= 3'd0;
      byteIdx  <= 2'd0;
      kindQ    <= KIND_RREG;
      spiCsN   <= 1'b1;
      spiSclk  <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      state    <= nxtState;
      cnt      <= nxtCnt;
      bitIdx   <= stb.bitIdx;
      byteIdx  <= stb.byteIdx;
      if (stb.accept) kindQ <= reqKind;
      spiSclk  <= (nxtState == ST_HIGH);
      spiCsN   <= (nxtState == ST_IDLE);
      rspValid <= (state == ST_FIN) && (kindQ != KIND_WREG);
    end
  end

endmodule

// File: rtl/adcseq_dp.sv
`timescale 1ns/1ps
module adcseq_dp
  import adcseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  kind_e       reqKind,
  input  logic [3:0]  reqAddr,
  input  logic [7:0]  reqData,
  input  stb_t        stb,
  input  logic        spiMiso,
  output logic        spiMosi,
  output logic [23:0] rspData
);

  kind_e      kindQ;
  logic [3:0] addrQ;
  logic [7:0] dataQ;
  logic [7:0] curByte;
  logic       inRsp;

  always_comb begin
    curByte = OP_NOP;
    case (stb.byteIdx)
      2'd0: begin
        if (kindQ == KIND_RDATA)     curByte = OP_RDATA;
        else if (kindQ == KIND_WREG) curByte = {OP_WREG_HI, addrQ};
        else                         curByte = {OP_RREG_HI, addrQ};
      end
      2'd2:    curByte = (kindQ == KIND_WREG) ? dataQ : OP_NOP;
      default: curByte = OP_NOP;
    endcase
  end

  assign inRsp = ({1'b0, stb.byteIdx} >= cmdBytes(kindQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      kindQ   <= KIND_RREG;
      addrQ   <= 4'h0;
      dataQ   <= 8'h00;
      spiMosi <= 1'b0;
      rspData <= 24'h0;
    end else begin
      if (stb.accept) begin
        kindQ   <= reqKind;
        addrQ   <= reqAddr;
        dataQ   <= reqData;
        rspData <= 24'h0;
      end
      if (stb.rise)
        spiMosi <= curByte[~stb.bitIdx];
      else if (stb.clrMosi)
        spiMosi <= 1'b0;
      if (stb.fall && inRsp)
        rspData <= {rspData[22:0], spiMiso};
    end
  end

endmodule

// File: rtl/adc_cmd_seq.sv
`timescale 1ns/1ps
module adc_cmd_seq
  import adcseq_pkg::*;
#(
  parameter int DIV_CYC  = 4,
  parameter int WAIT_CYC = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqKind,
  input  logic [3:0]  reqAddr,
  input  logic [7:0]  reqData,
  output logic        rspValid,
  output logic [23:0] rspData,
  output logic        spiCsN,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso
);

  stb_t  stb;
  kind_e kindIn;

  assign kindIn = kind_e'(reqKind);

  adcseq_ctrl #(.DIV_CYC(DIV_CYC), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(kindIn),
    .reqReady(reqReady), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .rspValid(rspValid), .stb(stb)
  );

  adcseq_dp u_dp (
    .clk(clk), .rst(rst), .reqKind(kindIn), .reqAddr(reqAddr),
    .reqData(reqData), .stb(stb), .spiMiso(spiMiso),
    .spiMosi(spiMosi), .rspData(rspData)
  );

endmodule

// File: rtl/adcseq_chk.sv
`timescale 1ns/1ps
module adcseq_chk #(
  parameter int DIV_CYC  = 4,
  parameter int WAIT_CYC = 50
) (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic        reqReady,
  input logic [1:0]  reqKind,
  input logic        rspValid,
  input logic        spiCsN,
  input logic        spiSclk,
  input logic        spiMosi
);

  localparam int HALF = DIV_CYC / 2;
  localparam int RW   = $clog2(DIV_CYC + 2);
  localparam int GW   = $clog2(WAIT_CYC + DIV_CYC + 2);

  logic          sclkQ;
  logic [RW-1:0] runLen;
  logic [GW-1:0] gapCnt;
  logic [5:0]    risesDone;
  logic [1:0]    kindL;
  logic [5:0]    cmdBits;
  logic          isRead, sclkRise, sclkFall;

  assign sclkRise = spiSclk && !sclkQ;
  assign sclkFall = !spiSclk && sclkQ;
  assign isRead   = (kindL != 2'd1);
  assign cmdBits  = (kindL == 2'd1) ? 6'd24 : (kindL == 2'd2) ? 6'd8 : 6'd16;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ     <= 1'b0;
      runLen    <= '1;
      gapCnt    <= '1;
      risesDone <= 6'd0;
      kindL     <= 2'd0;
    end else begin
      sclkQ <= spiSclk;
      if (spiSclk != sclkQ)  runLen <= RW'(1);
      else if (runLen != '1) runLen <= runLen + 1'b1;
      if (sclkFall)          gapCnt <= '0;
      else if (gapCnt != '1) gapCnt <= gapCnt + 1'b1;
      if (reqValid && reqReady) begin
        kindL     <= reqKind;
        risesDone <= 6'd0;
      end else if (sclkRise && risesDone != 6'h3f) begin
        risesDone <= risesDone + 6'd1;
      end
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst) reqReady |-> spiCsN) else $error("ready during frame"); // R1
  AST_SCLK_HALF: assert property (@(posedge clk) disable iff (rst) (spiSclk != sclkQ) |-> (runLen >= RW'(HALF))) else $error("sclk phase short"); // R2
  AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (rst) spiSclk |-> !spiCsN) else $error("sclk outside frame"); // R2
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst) (spiSclk && sclkQ) |-> $stable(spiMosi)) else $error("mosi moved in high phase"); // R3
  AST_NOP_FILL: assert property (@(posedge clk) disable iff (rst) (!spiCsN && isRead && risesDone > cmdBits) |-> !spiMosi) else $error("non-nop in readout"); // R6
  AST_RESP_WAIT: assert property (@(posedge clk) disable iff (rst) (sclkRise && isRead && risesDone == cmdBits) |-> (gapCnt >= GW'(WAIT_CYC))) else $error("response wait short"); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst) rspValid |=> !rspValid) else $error("rsp pulse long"); // R8
  AST_RSP_AT_RELEASE: assert property (@(posedge clk) disable iff (rst) rspValid |-> $rose(spiCsN)) else $error("rsp not at release"); // R8
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst) rspValid |-> isRead) else $error("rsp after write"); // R5

endmodule

bind adc_cmd_seq adcseq_chk #(.DIV_CYC(DIV_CYC), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqKind(reqKind), .rspValid(rspValid), .spiCsN(spiCsN),
  .spiSclk(spiSclk), .spiMosi(spiMosi)
);

// File: tb/sim_adc_cmd_seq.sv
`timescale 1ns/1ps
module sim_adc_cmd_seq;

  localparam int DIV_CYC  = 4;
  localparam int WAIT_CYC = 50;
  localparam int HALF     = DIV_CYC / 2;
  localparam int PER      = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = 2'd0;
  logic [3:0]  reqAddr = 4'h0;
  logic [7:0]  reqData = 8'h00;
  logic        rspValid;
  logic [23:0] rspData;
  logic        spiCsN, spiSclk, spiMosi;
  logic        spiMiso = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  adc_cmd_seq #(.DIV_CYC(DIV_CYC), .WAIT_CYC(WAIT_CYC)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData), .spiCsN(spiCsN),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // converter model
  logic [7:0]  regsM [16];
  logic [31:0] misoPat = 32'h0;
  logic [31:0] mosiCap = 32'h0;
  int          riseCnt = 0;
  int          fallCnt = 0;
  int          gapBits = 99;
  time         lastFall = 0;
  time         lastEdge = 0;
  time         gapMeas  = 0;
  time         minHigh  = 1000000;
  time         minLow   = 1000000;

  initial for (int i = 0; i < 16; i++) regsM[i] = 8'(i * 17 + 9);

  always @(negedge spiCsN) begin
    riseCnt = 0;
    fallCnt = 0;
    mosiCap = 32'h0;
  end

  always @(posedge spiSclk) begin
    if (riseCnt > 0 && ($time - lastEdge) < minLow) minLow = $time - lastEdge;
    if (riseCnt == gapBits) gapMeas = $time - lastFall;
    if (riseCnt < 32) spiMiso <= misoPat[31 - riseCnt];
    riseCnt  = riseCnt + 1;
    lastEdge = $time;
  end

  always @(negedge spiSclk) begin
    if (($time - lastEdge) < minHigh) minHigh = $time - lastEdge;
    mosiCap  = {mosiCap[30:0], spiMosi};
    fallCnt  = fallCnt + 1;
    lastFall = $time;
    lastEdge = $time;
  end

  always @(posedge spiCsN) begin
    if (fallCnt == 24 && mosiCap[23:20] == 4'h5)
      regsM[mosiCap[19:16]] = mosiCap[7:0];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runReq(input logic [1:0] kind, input logic [3:0] addr,
                        input logic [7:0] data, input logic [23:0] word);
    logic [31:0] expFrame;
    int          expBits;
    logic        rv;
    logic [23:0] rd;
    logic [23:0] expRsp;
    case (kind)
      2'd0: begin
        misoPat  = {16'h0, regsM[addr], 8'h0};
        expRsp   = {16'h0, regsM[addr]};
        expFrame = {8'h0, 4'h1, addr, 16'h0};
        expBits  = 24;
        gapBits  = 16;
      end
      2'd1: begin
        misoPat  = 32'h0;
        expRsp   = 24'h0;
        expFrame = {8'h0, 4'h5, addr, 8'h00, data};
        expBits  = 24;
        gapBits  = 99;
      end
      default: begin
        misoPat  = {8'h0, word};
        expRsp   = word;
        expFrame = 32'h0300_0000;
        expBits  = 32;
        gapBits  = 8;
      end
    endcase
    gapMeas = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    chk(!reqReady && !spiCsN, "R1 held off during frame", {30'h0, reqReady, spiCsN}, 32'h0);
    do @(negedge clk); while (spiCsN == 1'b0);
    rv = rspValid;
    rd = rspData;
    chk(fallCnt == expBits, "R8 frame length", 32'(fallCnt), 32'(expBits));
    chk(mosiCap == expFrame, (kind == 2'd1) ? "R5 write frame" : (kind == 2'd0) ? "R4 read frame nop" : "R6 data frame nop",
        mosiCap, expFrame);
    if (kind == 2'd1) begin
      chk(rv == 1'b0, "R5 no response", {31'h0, rv}, 32'h0);
    end else begin
      chk(rv == 1'b1, "R8 valid at release", {31'h0, rv}, 32'h1);
      chk(rd == expRsp, (kind == 2'd0) ? "R4 register byte" : "R6 msb first word", {8'h0, rd}, {8'h0, expRsp});
      chk(gapMeas >= WAIT_CYC * PER, "R7 response wait", 32'(gapMeas), 32'(WAIT_CYC * PER));
      @(negedge clk);
      chk(rspValid == 1'b0, "R8 single cycle pulse", {31'h0, rspValid}, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spiCsN && !spiSclk && !spiMosi && !rspValid && reqReady, "R9 reset state",
        {27'h0, spiCsN, spiSclk, spiMosi, rspValid, reqReady}, 32'h11);

    // read defaults of every register
    for (int a = 0; a < 16; a++) runReq(2'd0, 4'(a), 8'h00, 24'h0);
    // write every register, then read all back
    for (int a = 0; a < 16; a++) runReq(2'd1, 4'(a), 8'(a * 29 + 7), 24'h0);
    for (int a = 0; a < 16; a++) begin
      runReq(2'd0, 4'(a), 8'h00, 24'h0);
      chk(regsM[a] == 8'(a * 29 + 7), "R5 round trip", {24'h0, regsM[a]}, {24'h0, 8'(a * 29 + 7)});
    end
    // data-rate register style round trip
    runReq(2'd1, 4'h3, 8'h33, 24'h0);
    runReq(2'd0, 4'h3, 8'h00, 24'h0);
    chk(regsM[3] == 8'h33, "R5 addr3 value", {24'h0, regsM[3]}, 32'h33);
    // conversion words
    runReq(2'd2, 4'h0, 8'h00, 24'h000000);
    runReq(2'd2, 4'h0, 8'h00, 24'hFFFFFF);
    runReq(2'd2, 4'h0, 8'h00, 24'h800000);
    runReq(2'd2, 4'h0, 8'h00, 24'h000001);
    runReq(2'd2, 4'h0, 8'h00, 24'hA5C33C);
    runReq(2'd2, 4'h0, 8'h00, 24'h123456);
    // clock phases, R3 bit order covered by the frame compares above
    chk(minHigh >= HALF * PER, "R2 high phase", 32'(minHigh), 32'(HALF * PER));
    chk(minLow >= HALF * PER, "R2 low phase", 32'(minLow), 32'(HALF * PER));
    chk(mosiCap[31:24] == 8'h03, "R3 msb first opcode", {24'h0, mosiCap[31:24]}, 32'h03);
    repeat (4) @(negedge clk);
    chk(spiCsN && !spiSclk && reqReady, "R2 idle sclk low", {29'h0, spiCsN, spiSclk, reqReady}, 32'h5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule